// File: doc/BRIEF.md
# Two-Thread Watermarked Slot Allocator

This block tracks how many entries of a shared pool (scheduler slots, buffer slots and similar) each of two hardware threads holds. It does not store the entries. Each cycle, every thread may release a number of entries and ask for a number of new ones. The block answers each allocation request with a grant in the same cycle. The per-thread occupancy registers take the new values at the next clock edge.

With one thread running, the selected thread may fill the whole pool and the idle thread gets nothing. With two threads running, the pool is shared on demand, but a programmable watermark protects each thread. A request is refused if, after it, the other thread could no longer reach the watermark level of holdings from the free entries that remain. This keeps one thread from draining the pool while its sibling is stalled. When both requests fit on their own but not together, the winner alternates between the threads. The block also reports which thread feeds each of the two front-end decoders.

Top module: `smtPoolAllocator`

## Requirements
- R1: After a synchronous active-low reset, both occupancy counts are 0 and the first contended cycle favours thread 0.
- R2: When `dualMode` is 0, only the thread named by `activeThread` can be granted. It is granted whenever its count does not exceed the free entries, with no watermark applied. Requests from the other thread are never granted.
- R3: When `dualMode` is 1 and one thread requests alone, the grant is given only if the count fits in the free entries and the entries left over are at least the other thread's shortfall. The shortfall is the watermark minus that thread's holdings, or 0 if the holdings already reach the watermark.
- R4: When `dualMode` is 1 and both threads request, both are granted if both counts fit together and the entries left over cover the shortfall of each thread, computed from its holdings after this cycle's grant.
- R5: When each request fits alone but not both together, exactly one thread is granted. The first such cycle after reset favours thread 0, and each later such cycle favours the thread that lost the previous one.
- R6: Releases are applied before allocations. The free-entry count used for this cycle's grants already includes the entries released in the same cycle.
- R7: A release count larger than a thread's holdings empties that thread to 0 and never wraps.
- R8: One edge after a cycle, each thread's occupancy equals its holdings minus the entries it released (clamped at 0), plus its count if it was granted.
- R9: `decOwner` bit i names the thread that feeds decoder i. With `dualMode` = 1 it is 2'b10 (decoder 0 from thread 0, decoder 1 from thread 1). With `dualMode` = 0, both bits equal `activeThread`.
- R10: The sum of the two occupancy counts never exceeds the pool size (64 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| dualMode | input | 1 | 1: two threads share the pool; 0: one thread owns it |
| activeThread | input | 1 | Thread that runs when dualMode is 0 |
| reserveLevel | input | OCC_W (7) | Watermark held back for each thread in dual mode |
| allocReq | input | 2 | Bit t: thread t asks for entries this cycle |
| allocCnt0 | input | REQ_W (4) | Entries asked for by thread 0 |
| allocCnt1 | input | REQ_W (4) | Entries asked for by thread 1 |
| freeCnt0 | input | REQ_W (4) | Entries released by thread 0 |
| freeCnt1 | input | REQ_W (4) | Entries released by thread 1 |
| allocGrant | output | 2 | Bit t: thread t's request is granted this cycle |
| occ0 | output | OCC_W (7) | Entries held by thread 0 |
| occ1 | output | OCC_W (7) | Entries held by thread 1 |
| decOwner | output | 2 | Bit i: thread that feeds decoder i |

## Verification
Grants and decoder ownership are combinational. They are due in the same cycle as the request, so the bench samples them 3 ns after the falling edge at which it changed the inputs. Occupancy is due one rising edge later, and the bench reads it 1 ns after that edge. A scoreboard item is pushed at each drive and popped once both samples of that cycle exist. The directed phases produce the watermark-edge, clamp, same-cycle release and alternating-contention cases at exact counts. A pseudo-random phase then mixes modes, watermark values and counts.

// File: rtl/allocPkg.sv
package allocPkg;
  localparam int WideW = 16;
  typedef logic [WideW-1:0] wide_t;

  // strobes from control to the occupancy datapath
  typedef struct packed {
    logic [1:0] grant;
  } allocStrobe_t;

  // entries still needed to bring a thread up to the watermark
  function automatic wide_t shortfall(input wide_t rsv, input wide_t held);
    return (rsv > held) ? rsv - held : '0;
  endfunction
endpackage

// File: rtl/allocCtrl.sv
module allocCtrl import allocPkg::*; #(
  parameter int POOL_SIZE = 64,
  parameter int OCC_W = 7,
  parameter int REQ_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               dualMode,
  input  logic               activeThread,
  input  logic [OCC_W-1:0]   reserveLevel,
  input  logic [1:0]         allocReq,
  input  logic [1:0][REQ_W-1:0] allocCnt,
  input  logic [1:0][OCC_W-1:0] postOcc,
  output allocStrobe_t       strobe,
  output logic [1:0]         decOwner
);
  logic  rrPrio;
  logic  contend;
  logic  jointFit;
  logic  [1:0] fitAlone;
  logic  [1:0] threadLive;
  wide_t poolW, freeW, rsvW, sumW;
  wide_t heldW [2];
  wide_t cntW  [2];

  assign poolW = wide_t'(POOL_SIZE);
  assign rsvW  = dualMode ? wide_t'(reserveLevel) : '0;
  assign threadLive = dualMode ? 2'b11 : (activeThread ? 2'b10 : 2'b01);

  for (genvar t = 0; t < 2; t++) begin : gIn
    assign heldW[t] = wide_t'(postOcc[t]);
    assign cntW[t]  = wide_t'(allocCnt[t]);
  end

  assign freeW = poolW - heldW[0] - heldW[1];
  assign sumW  = cntW[0] + cntW[1];

  for (genvar t = 0; t < 2; t++) begin : gFit
    assign fitAlone[t] = allocReq[t] && threadLive[t] && (cntW[t] <= freeW) &&
                         ((freeW - cntW[t]) >= shortfall(rsvW, heldW[1-t]));
  end

  assign jointFit = (sumW <= freeW) &&
                    ((freeW - sumW) >= shortfall(rsvW, heldW[0] + cntW[0])) &&
                    ((freeW - sumW) >= shortfall(rsvW, heldW[1] + cntW[1]));

  always_comb begin
    contend      = 1'b0;
    strobe.grant = fitAlone;
    if (fitAlone == 2'b11 && !jointFit) begin
      contend      = 1'b1;
      strobe.grant = rrPrio ? 2'b10 : 2'b01;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        rrPrio <= 1'b0;
    else if (contend) rrPrio <= ~rrPrio;
  end

  assign decOwner = dualMode ? 2'b10 : {activeThread, activeThread};
endmodule

// File: rtl/poolOccPath.sv
module poolOccPath import allocPkg::*; #(
  parameter int OCC_W = 7,
  parameter int REQ_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0][REQ_W-1:0] freeCnt,
  input  logic [1:0][REQ_W-1:0] allocCnt,
  input  allocStrobe_t       strobe,
  output logic [1:0][OCC_W-1:0] occ,
  output logic [1:0][OCC_W-1:0] postOcc
);
  for (genvar t = 0; t < 2; t++) begin : gThr
    logic [OCC_W-1:0] occR;
    wide_t heldW, relW, nextW;

    assign heldW = wide_t'(occR);
    // releases first, clamped at zero
    assign relW  = (wide_t'(freeCnt[t]) >= heldW) ? '0 : heldW - wide_t'(freeCnt[t]);
    assign nextW = relW + (strobe.grant[t] ? wide_t'(allocCnt[t]) : '0);

    always_ff @(posedge clk) begin
      if (!rstN) occR <= '0;
      else       occR <= OCC_W'(nextW);
    end

    assign postOcc[t] = OCC_W'(relW);
    assign occ[t]     = occR;
  end
endmodule

// File: rtl/smtPoolAllocator.sv
module smtPoolAllocator import allocPkg::*; #(
  parameter int POOL_SIZE = 64,
  parameter int REQ_W = 4,
  localparam int OCC_W = $clog2(POOL_SIZE + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dualMode,
  input  logic             activeThread,
  input  logic [OCC_W-1:0] reserveLevel,
  input  logic [1:0]       allocReq,
  input  logic [REQ_W-1:0] allocCnt0,
  input  logic [REQ_W-1:0] allocCnt1,
  input  logic [REQ_W-1:0] freeCnt0,
  input  logic [REQ_W-1:0] freeCnt1,
  output logic [1:0]       allocGrant,
  output logic [OCC_W-1:0] occ0,
  output logic [OCC_W-1:0] occ1,
  output logic [1:0]       decOwner
);
  allocStrobe_t strobe;
  logic [1:0][REQ_W-1:0] allocArr, freeArr;
  logic [1:0][OCC_W-1:0] occArr, postArr;

  assign allocArr = {allocCnt1, allocCnt0};
  assign freeArr  = {freeCnt1, freeCnt0};

  allocCtrl #(.POOL_SIZE(POOL_SIZE), .OCC_W(OCC_W), .REQ_W(REQ_W)) ctrl (
    .clk(clk), .rstN(rstN), .dualMode(dualMode), .activeThread(activeThread),
    .reserveLevel(reserveLevel), .allocReq(allocReq), .allocCnt(allocArr),
    .postOcc(postArr), .strobe(strobe), .decOwner(decOwner)
  );

  poolOccPath #(.OCC_W(OCC_W), .REQ_W(REQ_W)) path (
    .clk(clk), .rstN(rstN), .freeCnt(freeArr), .allocCnt(allocArr),
    .strobe(strobe), .occ(occArr), .postOcc(postArr)
  );

  assign allocGrant = strobe.grant;
  assign occ0 = occArr[0];
  assign occ1 = occArr[1];
endmodule

// File: rtl/smtPoolAllocatorChecker.sv
module smtPoolAllocatorChecker #(
  parameter int POOL_SIZE = 64,
  parameter int REQ_W = 4,
  parameter int OCC_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             dualMode,
  input logic             activeThread,
  input logic [OCC_W-1:0] reserveLevel,
  input logic [REQ_W-1:0] allocCnt0,
  input logic [REQ_W-1:0] allocCnt1,
  input logic [REQ_W-1:0] freeCnt0,
  input logic [REQ_W-1:0] freeCnt1,
  input logic [1:0]       allocGrant,
  input logic [OCC_W-1:0] occ0,
  input logic [OCC_W-1:0] occ1,
  input logic [1:0]       decOwner
);
  a_r10_pool_bound: assert property (@(posedge clk) disable iff (!rstN)
    (int'(occ0) + int'(occ1)) <= POOL_SIZE);

  a_r2_idle_thread_denied: assert property (@(posedge clk) disable iff (!rstN)
    !dualMode |-> !allocGrant[!activeThread]);

  a_r9_dual_decoders: assert property (@(posedge clk) disable iff (!rstN)
    dualMode |-> decOwner == 2'b10);

  a_r9_single_decoders: assert property (@(posedge clk) disable iff (!rstN)
    !dualMode |-> decOwner == {activeThread, activeThread});

  a_r7_clamp_thread0: assert property (@(posedge clk) disable iff (!rstN)
    (int'(freeCnt0) >= int'(occ0)) |=>
      int'(occ0) == ($past(allocGrant[0]) ? int'($past(allocCnt0)) : 0));

  a_r7_clamp_thread1: assert property (@(posedge clk) disable iff (!rstN)
    (int'(freeCnt1) >= int'(occ1)) |=>
      int'(occ1) == ($past(allocGrant[1]) ? int'($past(allocCnt1)) : 0));

  a_r3_reserve_for_thread1: assert property (@(posedge clk) disable iff (!rstN)
    (dualMode && allocGrant[0]) |=>
      (POOL_SIZE - int'(occ0) - int'(occ1)) >=
      ((int'($past(reserveLevel)) > int'(occ1)) ? int'($past(reserveLevel)) - int'(occ1) : 0));

  a_r3_reserve_for_thread0: assert property (@(posedge clk) disable iff (!rstN)
    (dualMode && allocGrant[1]) |=>
      (POOL_SIZE - int'(occ0) - int'(occ1)) >=
      ((int'($past(reserveLevel)) > int'(occ0)) ? int'($past(reserveLevel)) - int'(occ0) : 0));
endmodule

bind smtPoolAllocator smtPoolAllocatorChecker #(
  .POOL_SIZE(POOL_SIZE), .REQ_W(REQ_W), .OCC_W(OCC_W)
) chk (
  .clk(clk), .rstN(rstN), .dualMode(dualMode), .activeThread(activeThread),
  .reserveLevel(reserveLevel), .allocCnt0(allocCnt0), .allocCnt1(allocCnt1),
  .freeCnt0(freeCnt0), .freeCnt1(freeCnt1), .allocGrant(allocGrant),
  .occ0(occ0), .occ1(occ1), .decOwner(decOwner)
);

// File: tb/smtPoolAllocator_test.sv
module smtPoolAllocator_test;
  localparam int POOL = 64;
  localparam int RW = 4;
  localparam int OW = $clog2(POOL + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dualMode = 1'b0, activeThread = 1'b0;
  logic [OW-1:0] reserveLevel = '0;
  logic [1:0] allocReq = '0;
  logic [RW-1:0] allocCnt0 = '0, allocCnt1 = '0, freeCnt0 = '0, freeCnt1 = '0;
  logic [1:0] allocGrant, decOwner;
  logic [OW-1:0] occ0, occ1;

  int checks = 0;
  int errors = 0;
  int mOcc0 = 0, mOcc1 = 0;
  bit mRr = 1'b0;

  typedef struct {
    logic [1:0] grant;
    logic [1:0] dec;
    int occ0;
    int occ1;
    string tag;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  smtPoolAllocator #(.POOL_SIZE(POOL), .REQ_W(RW)) uut (
    .clk(clk), .rstN(rstN), .dualMode(dualMode), .activeThread(activeThread),
    .reserveLevel(reserveLevel), .allocReq(allocReq), .allocCnt0(allocCnt0),
    .allocCnt1(allocCnt1), .freeCnt0(freeCnt0), .freeCnt1(freeCnt1),
    .allocGrant(allocGrant), .occ0(occ0), .occ1(occ1), .decOwner(decOwner)
  );

  function automatic int shortOf(int r, int held);
    return (r > held) ? r - held : 0;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected outcome
  task automatic step(bit md, bit at, int rsv, bit r0, int c0, int f0,
                      bit r1, int c1, int f1, string tag);
    item_t it;
    int p0, p1, fr, r;
    bit a0, a1, fit0, fit1, joint;
    logic [1:0] g;
    @(negedge clk);
    dualMode = md; activeThread = at; reserveLevel = OW'(rsv);
    allocReq = {r1, r0};
    allocCnt0 = RW'(c0); allocCnt1 = RW'(c1);
    freeCnt0 = RW'(f0); freeCnt1 = RW'(f1);
    p0 = (f0 >= mOcc0) ? 0 : mOcc0 - f0;   // R6 / R7
    p1 = (f1 >= mOcc1) ? 0 : mOcc1 - f1;
    fr = POOL - p0 - p1;
    r  = md ? rsv : 0;
    a0 = md || !at;
    a1 = md || at;
    fit0 = r0 && a0 && (c0 <= fr) && ((fr - c0) >= shortOf(r, p1));
    fit1 = r1 && a1 && (c1 <= fr) && ((fr - c1) >= shortOf(r, p0));
    joint = (c0 + c1 <= fr) && ((fr - c0 - c1) >= shortOf(r, p0 + c0)) &&
            ((fr - c0 - c1) >= shortOf(r, p1 + c1));
    g = {fit1, fit0};
    if (fit0 && fit1 && !joint) begin     // R5
      g = mRr ? 2'b10 : 2'b01;
      mRr = ~mRr;
    end
    mOcc0 = p0 + (g[0] ? c0 : 0);
    mOcc1 = p1 + (g[1] ? c1 : 0);
    it.grant = g;
    it.dec = md ? 2'b10 : {at, at};
    it.occ0 = mOcc0;
    it.occ1 = mOcc1;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(bit md, bit at, int n);
    for (int i = 0; i < n; i++) step(md, at, 0, 0, 0, 0, 0, 0, 0, "R8");
  endtask

  // monitor: grant/decoder mid-cycle, occupancy after the next rising edge
  initial begin
    logic [1:0] gS, dS;
    item_t it;
    forever begin
      @(negedge clk); #3;
      gS = allocGrant; dS = decOwner;
      @(posedge clk); #1;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        check(it.tag, "grant", int'(gS), int'(it.grant));
        check("R9", "decOwner", int'(dS), int'(it.dec));
        check(it.tag, "occ0", int'(occ0), it.occ0);
        check(it.tag, "occ1", int'(occ1), it.occ1);
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1", "occ0 after reset", int'(occ0), 0);
    check("R1", "occ1 after reset", int'(occ1), 0);
    check("R1", "grant idle", int'(allocGrant), 0);

    // single-thread: thread 0 fills the whole pool
    for (int i = 0; i < 4; i++) step(0, 0, 8, 1, 15, 0, 0, 0, 0, "R2");
    step(0, 0, 8, 1, 15, 0, 1, 1, 0, "R2");       // 4 free: both denied
    step(0, 0, 8, 1, 4, 0, 1, 1, 0, "R2");        // fills to 64, no watermark
    step(0, 0, 8, 1, 5, 5, 0, 0, 0, "R6");        // release and take 5 together
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 15, 0, 0, 0, "R7");
    // single-thread on thread 1
    step(0, 1, 8, 1, 3, 0, 1, 9, 0, "R2");
    step(0, 1, 8, 0, 0, 0, 0, 0, 15, "R7");

    // dual mode, watermark 8
    for (int i = 0; i < 3; i++) step(1, 0, 8, 1, 15, 0, 0, 0, 0, "R3");
    step(1, 0, 8, 1, 15, 0, 0, 0, 0, "R3");       // leaves 4 < 8: denied
    step(1, 0, 8, 1, 11, 0, 0, 0, 0, "R3");       // leaves exactly 8
    step(1, 0, 8, 1, 1, 0, 0, 0, 0, "R3");        // leaves 7: denied
    step(1, 0, 8, 0, 0, 0, 1, 8, 0, "R3");        // thread 1 takes its reserve
    for (int i = 0; i < 4; i++) step(1, 0, 8, 0, 0, 15, 0, 0, 15, "R7");

    // joint grants
    step(1, 0, 8, 1, 10, 0, 1, 10, 0, "R4");
    step(1, 0, 8, 1, 12, 0, 1, 12, 0, "R4");
    // contention: 20 free, both ask 15
    step(1, 0, 8, 1, 15, 0, 1, 15, 0, "R5");
    step(1, 0, 8, 1, 15, 15, 1, 15, 0, "R5");
    step(1, 0, 8, 1, 15, 0, 1, 15, 15, "R5");
    step(1, 0, 8, 1, 15, 15, 1, 15, 0, "R5");
    idle(1, 0, 2);

    // mixed pseudo-random traffic
    for (int i = 0; i < 600; i++) begin
      bit md = (i % 150) < 110;
      step(md, bit'($urandom_range(0, 1)), int'($urandom_range(0, 16)),
           bit'($urandom_range(0, 1)), int'($urandom_range(0, 15)), int'($urandom_range(0, 12)),
           bit'($urandom_range(0, 1)), int'($urandom_range(0, 15)), int'($urandom_range(0, 12)),
           "R8");
    end
    for (int i = 0; i < 6; i++) step(1, 0, 8, 0, 0, 15, 0, 0, 15, "R10");
    idle(1, 0, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule